// File: doc/BRIEF.md
# Integer Execute Unit with Immediate Extension

This block is the integer execute stage of a load-store RISC core. Each cycle it takes two register operands, a 16-bit immediate, a 5-bit constant shift count and a decoded operation code. It returns a 32-bit result and a flag that marks signed overflow on the trapping add and subtract forms. Both outputs are registered, so a result appears one clock after its operands.

The operations are add and subtract, in trapping and non-trapping forms. There are four bitwise logic operations: AND, OR, XOR and NOR. There are left, logical-right and arithmetic-right shifts, by a constant or by a register. There are signed and unsigned set-less-than, and a load-upper-immediate.

How the immediate is widened depends on the operation class. Logic immediates are zero-filled. Arithmetic and compare immediates are sign-filled. Multiply, divide, fetch and writeback belong to other blocks. When overflow is flagged, the surrounding pipeline decides whether to cancel the write.

Top module: `int_exec_unit`

## Requirements
- R1: `op_i` selects the operation with these codes: ADD=0, ADDU=1, SUB=2, SUBU=3, AND=4, OR=5, XOR=6, NOR=7, ADDI=8, ADDIU=9, ANDI=10, ORI=11, XORI=12, SLT=13, SLTU=14, SLTI=15, SLTIU=16, SLL=17, SRL=18, SRA=19, SLLV=20, SRLV=21, SRAV=22, LUI=23. Codes 24 to 31 give a zero result with no flag. Add and subtract forms return the 32-bit wrapped sum or difference (rs+rt, rs-rt, or rs+immediate).
- R2: AND, OR, XOR and NOR combine rs and rt bit by bit across all 32 bits.
- R3: ANDI, ORI and XORI zero-extend the immediate to 32 bits before combining it with rs.
- R4: ADDI and ADDIU sign-extend the immediate (bit 15 copied into bits 31:16).
- R5: `ovf_o` is 1 only for ADD, SUB and ADDI, and only when the two's-complement result does not fit in 32 bits. For subtraction this is judged on rs plus the negated rt. All other codes leave it 0.
- R6: When overflow is flagged, `result_o` still carries the wrapped result.
- R7: SLT and SLTI compare as two's complement. SLTU and SLTIU compare as unsigned numbers. SLTI and SLTIU use the sign-extended immediate. The result is 1 or 0, with bits 31:1 zero.
- R8: LUI returns the immediate in bits 31:16 and zero in bits 15:0.
- R9: SLL, SRL and SRA shift rt by `shamt_i`. SRA fills the vacated bits with rt bit 31, and SRL and SLL fill with zero.
- R10: SLLV, SRLV and SRAV shift rt by the low 5 bits of rs. The upper bits of rs are ignored.
- R11: The outputs are registered. Inputs presented before a rising edge appear on the outputs after that edge. While `rst` is high at an edge, both outputs become zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Decoded operation code |
| rs_val_i | input | 32 | First register operand |
| rt_val_i | input | 32 | Second register operand / shift source |
| imm_i | input | 16 | Instruction immediate |
| shamt_i | input | 5 | Constant shift count |
| result_o | output | 32 | Registered result |
| ovf_o | output | 1 | Registered signed-overflow flag |

## Verification
The bench aims at the boundary operands 0x7FFFFFFF, 0x80000000, all-ones, and immediates with bit 15 set. A unit that widened the immediate with the wrong rule would return wrong upper halves on ANDI or ADDIU. A unit that flagged overflow on ADDU or SUBU would raise `ovf_o` where none is allowed. Subtracting 0x80000000 probes the negated-operand overflow rule. A sign error in the comparators shows up as SLT and SLTU agreeing on mixed-sign operands. Shift counts of 0 and 31, together with register shift counts that have upper bits set, expose a shifter that fills with the wrong bit or uses too many amount bits.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;
  typedef enum logic [4:0] {
    OP_ADD   = 5'd0,  OP_ADDU  = 5'd1,  OP_SUB  = 5'd2,  OP_SUBU  = 5'd3,
    OP_AND   = 5'd4,  OP_OR    = 5'd5,  OP_XOR  = 5'd6,  OP_NOR   = 5'd7,
    OP_ADDI  = 5'd8,  OP_ADDIU = 5'd9,  OP_ANDI = 5'd10, OP_ORI   = 5'd11,
    OP_XORI  = 5'd12, OP_SLT   = 5'd13, OP_SLTU = 5'd14, OP_SLTI  = 5'd15,
    OP_SLTIU = 5'd16, OP_SLL   = 5'd17, OP_SRL  = 5'd18, OP_SRA   = 5'd19,
    OP_SLLV  = 5'd20, OP_SRLV  = 5'd21, OP_SRAV = 5'd22, OP_LUI   = 5'd23
  } exec_op_e;
  localparam int OP_W = 5;
endpackage

// File: rtl/exec_opnd_sel.sv
module exec_opnd_sel #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [DATA_W-1:0] rt_val_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              use_imm_i,
  input  logic              zero_ext_i,
  output logic [DATA_W-1:0] opnd_b_o
);
  localparam int PAD_W = DATA_W - IMM_W;
  logic [PAD_W-1:0] pad;

  always_comb begin
    pad = zero_ext_i ? '0 : {PAD_W{imm_i[IMM_W-1]}};
    opnd_b_o = use_imm_i ? {pad, imm_i} : rt_val_i;
  end
endmodule

// File: rtl/exec_addsub.sv
module exec_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              sovf_o
);
  logic [DATA_W-1:0] b_eff;

  always_comb begin
    b_eff  = sub_i ? ~b_i : b_i;
    sum_o  = a_i + b_eff + {{(DATA_W-1){1'b0}}, sub_i};
    sovf_o = (a_i[DATA_W-1] == b_eff[DATA_W-1]) && (sum_o[DATA_W-1] != a_i[DATA_W-1]);
  end
endmodule

// File: rtl/exec_shifter.sv
module exec_shifter #(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = 5
) (
  input  logic [DATA_W-1:0]  data_i,
  input  logic [SHAMT_W-1:0] amt_i,
  input  logic               left_i,
  input  logic               arith_i,
  output logic [DATA_W-1:0]  res_o
);
  logic [DATA_W-1:0] stage [0:SHAMT_W];
  logic              fill;

  assign fill     = arith_i & data_i[DATA_W-1];
  assign stage[0] = data_i;

  for (genvar g = 0; g < SHAMT_W; g++) begin : g_stage
    localparam int D = 1 << g;
    logic [DATA_W-1:0] shl, shr;
    assign shl = {stage[g][DATA_W-1-D:0], {D{1'b0}}};
    assign shr = {{D{fill}}, stage[g][DATA_W-1:D]};
    assign stage[g+1] = !amt_i[g] ? stage[g] : (left_i ? shl : shr);
  end

  assign res_o = stage[SHAMT_W];

  // R9: an arithmetic right shift keeps the sign bit of its source
  always_comb begin
    if (arith_i && !left_i) begin
      a_r9_sign_fill: assert (res_o[DATA_W-1] == data_i[DATA_W-1]);
    end
  end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import int_exec_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 16,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [OP_W-1:0]     op_i,
  input  logic [DATA_W-1:0]   rs_val_i,
  input  logic [DATA_W-1:0]   rt_val_i,
  input  logic [IMM_W-1:0]    imm_i,
  input  logic [SHAMT_W-1:0]  shamt_i,
  output logic [DATA_W-1:0]   result_o,
  output logic                ovf_o
);
  localparam int LOW_W = DATA_W - IMM_W;

  exec_op_e op;
  logic use_imm, zero_ext, is_sub, trap_op, is_slt, shl, sar, var_sh;
  logic [DATA_W-1:0]  b_val, sum, sh_res, res_d;
  logic [SHAMT_W-1:0] sh_amt;
  logic               sovf, lt_s, lt_u;

  assign op = exec_op_e'(op_i);

  always_comb begin
    use_imm  = op inside {OP_ADDI, OP_ADDIU, OP_ANDI, OP_ORI, OP_XORI, OP_SLTI, OP_SLTIU};
    zero_ext = op inside {OP_ANDI, OP_ORI, OP_XORI};
    is_sub   = op inside {OP_SUB, OP_SUBU, OP_SLT, OP_SLTU, OP_SLTI, OP_SLTIU};
    trap_op  = op inside {OP_ADD, OP_SUB, OP_ADDI};
    is_slt   = op inside {OP_SLT, OP_SLTU, OP_SLTI, OP_SLTIU};
    shl      = op inside {OP_SLL, OP_SLLV};
    sar      = op inside {OP_SRA, OP_SRAV};
    var_sh   = op inside {OP_SLLV, OP_SRLV, OP_SRAV};
    sh_amt   = var_sh ? rs_val_i[SHAMT_W-1:0] : shamt_i;
  end

  exec_opnd_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd (
    .rt_val_i(rt_val_i), .imm_i(imm_i), .use_imm_i(use_imm),
    .zero_ext_i(zero_ext), .opnd_b_o(b_val));

  exec_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_i(rs_val_i), .b_i(b_val), .sub_i(is_sub), .sum_o(sum), .sovf_o(sovf));

  exec_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shift (
    .data_i(rt_val_i), .amt_i(sh_amt), .left_i(shl), .arith_i(sar), .res_o(sh_res));

  // Signed less-than from the subtractor: sign of difference corrected by overflow
  assign lt_s = sum[DATA_W-1] ^ sovf;
  assign lt_u = rs_val_i < b_val;

  always_comb begin
    unique case (op)
      OP_ADD, OP_ADDU, OP_SUB, OP_SUBU, OP_ADDI, OP_ADDIU: res_d = sum;
      OP_AND, OP_ANDI: res_d = rs_val_i & b_val;
      OP_OR,  OP_ORI:  res_d = rs_val_i | b_val;
      OP_XOR, OP_XORI: res_d = rs_val_i ^ b_val;
      OP_NOR:          res_d = ~(rs_val_i | b_val);
      OP_SLT, OP_SLTI:   res_d = {{(DATA_W-1){1'b0}}, lt_s};
      OP_SLTU, OP_SLTIU: res_d = {{(DATA_W-1){1'b0}}, lt_u};
      OP_SLL, OP_SRL, OP_SRA, OP_SLLV, OP_SRLV, OP_SRAV: res_d = sh_res;
      OP_LUI:          res_d = {imm_i, {LOW_W{1'b0}}};
      default:         res_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      ovf_o    <= 1'b0;
    end else begin
      result_o <= res_d;
      ovf_o    <= trap_op & sovf;
    end
  end

  a_r5_ovf_trap_only: assert property (@(posedge clk) disable iff (rst)
    ovf_o |-> $past(trap_op));

  a_r7_slt_boolean: assert property (@(posedge clk) disable iff (rst)
    is_slt |=> (result_o[DATA_W-1:1] == '0));

  a_r8_lui_place: assert property (@(posedge clk) disable iff (rst)
    (op == OP_LUI) |=> (result_o == {$past(imm_i), {LOW_W{1'b0}}}));

  a_r3_logic_imm_high: assert property (@(posedge clk) disable iff (rst)
    (op == OP_ANDI) |=> (result_o[DATA_W-1:IMM_W] == '0));
endmodule

// File: tb/int_exec_unit_bench.sv
module int_exec_unit_bench;
  import int_exec_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  op_i = '0;
  logic [31:0] rs_val_i = '0, rt_val_i = '0;
  logic [15:0] imm_i = '0;
  logic [4:0]  shamt_i = '0;
  logic [31:0] result_o;
  logic        ovf_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  int_exec_unit u_int_exec_unit (
    .clk(clk), .rst(rst), .op_i(op_i), .rs_val_i(rs_val_i), .rt_val_i(rt_val_i),
    .imm_i(imm_i), .shamt_i(shamt_i), .result_o(result_o), .ovf_o(ovf_o));

  function automatic string tag_of(int op);
    if (op <= 3) return "R1";
    if (op <= 7) return "R2";
    if (op <= 9) return "R4";
    if (op <= 12) return "R3";
    if (op <= 16) return "R7";
    if (op <= 19) return "R9";
    if (op <= 22) return "R10";
    if (op == 23) return "R8";
    return "R1";
  endfunction

  // Behavioural reference: returns {ovf, result}
  function automatic logic [32:0] model(int op, logic [31:0] a, logic [31:0] b,
                                        logic [15:0] im, logic [4:0] sh);
    logic [31:0] sx = {{16{im[15]}}, im};
    logic [31:0] zx = {16'h0, im};
    longint s;
    logic [31:0] r = 0;
    logic ov = 0;
    case (op)
      0, 8: begin
        s = longint'($signed(a)) + longint'($signed(op == 0 ? b : sx));
        r = s[31:0]; ov = (s > 64'sd2147483647) || (s < -64'sd2147483648);
      end
      2: begin
        s = longint'($signed(a)) - longint'($signed(b));
        r = s[31:0]; ov = (s > 64'sd2147483647) || (s < -64'sd2147483648);
      end
      1: r = a + b;
      3: r = a - b;
      9: r = a + sx;
      4: r = a & b;   5: r = a | b;   6: r = a ^ b;   7: r = ~(a | b);
      10: r = a & zx; 11: r = a | zx; 12: r = a ^ zx;
      13: r = ($signed(a) < $signed(b)) ? 1 : 0;
      14: r = (a < b) ? 1 : 0;
      15: r = ($signed(a) < $signed(sx)) ? 1 : 0;
      16: r = (a < sx) ? 1 : 0;
      17: r = b << sh;
      18: r = b >> sh;
      19: r = $signed(b) >>> sh;
      20: r = b << a[4:0];
      21: r = b >> a[4:0];
      22: r = $signed(b) >>> a[4:0];
      23: r = {im, 16'h0};
      default: r = 0;
    endcase
    return {ov, r};
  endfunction

  task automatic run(int op, logic [31:0] a, logic [31:0] b, logic [15:0] im,
                     logic [4:0] sh, string tag);
    logic [32:0] exp;
    @(negedge clk);
    op_i = op[4:0]; rs_val_i = a; rt_val_i = b; imm_i = im; shamt_i = sh;
    exp = model(op, a, b, im, sh);
    @(negedge clk);
    checks++;
    if (result_o !== exp[31:0]) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h imm=%h sh=%0d result actual=%h expected=%h",
               tag, op, a, b, im, sh, result_o, exp[31:0]);
    end
    checks++;
    if (ovf_o !== exp[32]) begin
      errors++;
      $display("FAIL R5 op=%0d a=%h b=%h imm=%h ovf actual=%b expected=%b",
               op, a, b, im, ovf_o, exp[32]);
    end
  endtask

  initial begin
    #4000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  logic [31:0] corner [7] = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000,
                              32'hFFFF_FFFF, 32'h0000_FFFF, 32'h0000_8000};
  logic [15:0] imms [5] = '{16'h0, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h0001};
  logic [4:0]  shs  [3] = '{5'd0, 5'd1, 5'd31};

  initial begin
    // R11: reset drives outputs to zero
    op_i = 5'd23; imm_i = 16'hABCD;
    repeat (3) @(negedge clk);
    checks++;
    if (result_o !== 32'h0 || ovf_o !== 1'b0) begin
      errors++;
      $display("FAIL R11 reset outputs actual=%h/%b expected=0/0", result_o, ovf_o);
    end
    rst = 1'b0;

    // R6: wrapped result kept on overflow
    run(0, 32'h7FFF_FFFF, 32'h1, 16'h0, 5'd0, "R6");
    run(2, 32'h0, 32'h8000_0000, 16'h0, 5'd0, "R6");
    // R5: unsigned forms never flag
    run(1, 32'h7FFF_FFFF, 32'h1, 16'h0, 5'd0, "R5");
    run(9, 32'h7FFF_FFFF, 32'h0, 16'h7FFF, 5'd0, "R4");
    // R10: upper rs bits ignored for variable shifts
    run(20, 32'hFFFF_FFE3, 32'h0000_0001, 16'h0, 5'd0, "R10");
    run(22, 32'h0000_0124, 32'h8000_0000, 16'h0, 5'd0, "R10");
    // R9: sign fill
    run(19, 32'h0, 32'h8000_0000, 16'h0, 5'd31, "R9");
    run(18, 32'h0, 32'h8000_0000, 16'h0, 5'd31, "R9");
    // R7: signed vs unsigned disagree on mixed signs
    run(13, 32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0, "R7");
    run(14, 32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0, "R7");
    run(16, 32'h1, 32'h0, 16'hFFFF, 5'd0, "R7");
    // R3: zero-extended logic immediate
    run(11, 32'h0, 32'h0, 16'h8000, 5'd0, "R3");
    // R8
    run(23, 32'h1234_5678, 32'h0, 16'hBEEF, 5'd0, "R8");

    // Corner sweep across all codes (including unused ones, R1)
    for (int op = 0; op < 32; op++)
      for (int i = 0; i < 7; i++)
        for (int j = 0; j < 7; j++)
          run(op, corner[i], corner[j], imms[(i + j) % 5], shs[(i * j) % 3], tag_of(op));

    // Random operands
    for (int op = 0; op < 24; op++)
      for (int k = 0; k < 150; k++)
        run(op, $urandom, $urandom, 16'($urandom), 5'($urandom), tag_of(op));

    // R11: reset mid-run clears outputs
    @(negedge clk);
    op_i = 5'd23; imm_i = 16'hFFFF; rst = 1'b1;
    @(negedge clk);
    checks++;
    if (result_o !== 32'h0) begin
      errors++;
      $display("FAIL R11 reset clear actual=%h expected=00000000", result_o);
    end
    rst = 1'b0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule